// File: doc/BRIEF.md
# DDR Mode Register Command Tracker

This block sits on the device side of a DDR SDRAM model and follows the programming of its two mode registers. Each clock it takes one decoded command: register load, self refresh entry, self refresh exit, read, any other command, or no operation. With it come the two bank-select bits, the address bits and a flag that says whether all banks are idle. From this stream it keeps the operating parameters of the base register and the control bits of the extended register. It also tracks whether the delay-locked loop is running and counts the lock time before reads are allowed.

It also enforces the waits that follow a register load and a self refresh exit. A command that arrives too early, a load while banks are open, a reserved field value, and traffic after a loop reset that was never closed by a normal-mode load each raise a one-cycle violation pulse. The pulse carries a code that names the rule. A sticky error bit records that any violation has occurred since reset.

Top module: `ddr_mrs_tracker`

## Requirements
- R1: An active-low synchronous reset clears the stored operating parameters and the extended bits to zero. It also clears the loop-on and locked flags, the pending-reset status, the violation pulse, its code and the sticky error bit.
- R2: A load command (cmd 1) with bank bits 00 loads the base register. When address bits 7 to 11 are all zero, the load stores bits 0 to 6 as the operating parameters and clears the pending-reset status.
- R3: A base load with bit 8 set and bits 7, 9, 10 and 11 clear stores bits 0 to 6 and sets the pending-reset status. The status holds until a normal-mode base load. While it is set, a read (cmd 4) or other command (cmd 5) that breaks no timing rule gives code 5.
- R4: Three cases are reserved and give code 4 with no change to either register: a base load with any other pattern in bits 7 to 11, an extended load (bank bits 01) with any of bits 3 to 11 set, and a load with bank bit 1 set.
- R5: An accepted extended load stores bit 0 as the loop-disable bit, bit 1 as the drive-select bit and bit 2 as the bus-isolation enable. Bit 0 = 0 turns the loop on and bit 0 = 1 turns it off.
- R6: A load while banks_idle_i is low is rejected with code 3. This code wins over every other code.
- R7: After an accepted load, a load or other command in the next cycle is early: it gives code 2 and an early load is rejected. Two cycles after the load, the same command is legal. A rejected load starts no wait.
- R8: A read is early and gives code 1 in any of three cases: the loop is off, fewer than 200 cycles have passed since the loop last turned on, or it falls inside a post-load or post-exit wait. A read exactly 200 cycles after the loop turns on is legal, and the locked flag is then high.
- R9: Self refresh entry (cmd 2) turns the loop off. Self refresh exit (cmd 3) turns it back on when the stored disable bit is 0. After an exit, an other command needs 10 cycles and a read needs 200 cycles.
- R10: The violation pulse and its code appear in the cycle after the offending command and last one cycle. The code is 0 when there is no pulse. The sticky error bit is set with the first pulse and holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command: 0 none, 1 load, 2 self refresh entry, 3 self refresh exit, 4 read, 5 other |
| banks_idle_i | input | 1 | High when all banks are idle |
| ba_i | input | 2 | Bank-select bits sent with the command |
| addr_i | input | ADDR_W (12) | Address bits sent with the command |
| base_op_o | output | OP_W (7) | Stored operating parameters of the base register |
| ext_dll_dis_o | output | 1 | Stored loop-disable bit |
| ext_drive_o | output | 1 | Stored drive-select bit |
| ext_iso_o | output | 1 | Stored bus-isolation enable |
| dll_on_o | output | 1 | Loop is running |
| dll_locked_o | output | 1 | Loop is running and its lock time has elapsed |
| rst_pending_o | output | 1 | Loop reset requested and no normal-mode load seen since |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Violation code: 1 early read, 2 early command, 3 load while busy, 4 reserved, 5 missing normal load |
| err_sticky_o | output | 1 | Set by any violation until reset |

## Verification
Two rules can fall on the same command cycle, and the bench provokes each such overlap. A load with a reserved field is issued while banks are busy, and the result must be the busy code with no register change. A read is issued right after a base load while the loop is locked, so only the post-load wait can make it early, and it must be reported as an early read. In the third overlap, commands are sent while a loop reset is pending. One of them lands inside the post-load wait and must get the timing code, not the missing-load code. After the wait has ended, the same commands must give the missing-load code.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_MRS   = 3'd1,
      CMD_SRE   = 3'd2,
      CMD_SRX   = 3'd3,
      CMD_READ  = 3'd4,
      CMD_OTHER = 3'd5
   } cmd_e;

   typedef enum logic [2:0] {
      V_NONE      = 3'd0,
      V_EARLY_RD  = 3'd1,
      V_EARLY_CMD = 3'd2,
      V_BUSY      = 3'd3,
      V_RSV       = 3'd4,
      V_NO_NORM   = 3'd5
   } viol_e;

endpackage

// File: rtl/ddr_mrs_decode.sv
module ddr_mrs_decode #(
   parameter int ADDR_W = 12
) (
   input  logic [2:0]        cmd_i,
   input  logic [1:0]        ba_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              is_mrs_o,
   output logic              is_rd_o,
   output logic              is_oth_o,
   output logic              is_sre_o,
   output logic              is_srx_o,
   output logic              ld_base_o,
   output logic              ld_ext_o,
   output logic              base_norm_o,
   output logic              base_dllrst_o,
   output logic              rsv_o
);
   import ddr_mrs_pkg::*;

   localparam int HI_W = ADDR_W - 7;
   localparam logic [HI_W-1:0] DLLRST_PAT = HI_W'(2);

   logic [HI_W-1:0]     base_hi;
   logic [ADDR_W-4:0]   ext_hi;

   assign base_hi = addr_i[ADDR_W-1:7];
   assign ext_hi  = addr_i[ADDR_W-1:3];

   assign is_mrs_o = (cmd_i == CMD_MRS);
   assign is_rd_o  = (cmd_i == CMD_READ);
   assign is_oth_o = (cmd_i == CMD_OTHER);
   assign is_sre_o = (cmd_i == CMD_SRE);
   assign is_srx_o = (cmd_i == CMD_SRX);

   assign ld_base_o     = is_mrs_o && (ba_i == 2'b00);
   assign ld_ext_o      = is_mrs_o && (ba_i == 2'b01);
   assign base_norm_o   = (base_hi == '0);
   assign base_dllrst_o = (base_hi == DLLRST_PAT);

   always_comb begin
      rsv_o = 1'b0;
      if (is_mrs_o && ba_i[1])
         rsv_o = 1'b1;
      if (ld_base_o && !base_norm_o && !base_dllrst_o)
         rsv_o = 1'b1;
      if (ld_ext_o && (ext_hi != '0))
         rsv_o = 1'b1;
   end

endmodule

// File: rtl/ddr_wait_ctr.sv
module ddr_wait_ctr #(
   parameter int MAX_VAL = 1,
   localparam int CW = $clog2(MAX_VAL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          busy_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ddr_viol_arb.sv
module ddr_viol_arb (
   input  logic       f_busy_i,
   input  logic       f_early_cmd_i,
   input  logic       f_early_rd_i,
   input  logic       f_rsv_i,
   input  logic       f_no_norm_i,
   output logic [2:0] code_o
);
   import ddr_mrs_pkg::*;

   always_comb begin
      if (f_busy_i)
         code_o = V_BUSY;
      else if (f_early_cmd_i)
         code_o = V_EARLY_CMD;
      else if (f_early_rd_i)
         code_o = V_EARLY_RD;
      else if (f_rsv_i)
         code_o = V_RSV;
      else if (f_no_norm_i)
         code_o = V_NO_NORM;
      else
         code_o = V_NONE;
   end

endmodule

// File: rtl/ddr_mrs_tracker.sv
module ddr_mrs_tracker #(
   parameter int ADDR_W   = 12,
   parameter int OP_W     = 7,
   parameter int MRD_CYC  = 2,
   parameter int XSNR_CYC = 10,
   parameter int LOCK_CYC = 200,
   parameter bit ISO_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_i,
   input  logic              banks_idle_i,
   input  logic [1:0]        ba_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [OP_W-1:0]   base_op_o,
   output logic              ext_dll_dis_o,
   output logic              ext_drive_o,
   output logic              ext_iso_o,
   output logic              dll_on_o,
   output logic              dll_locked_o,
   output logic              rst_pending_o,
   output logic              viol_o,
   output logic [2:0]        viol_code_o,
   output logic              err_sticky_o
);
   import ddr_mrs_pkg::*;

   localparam int WIN_MAX = (MRD_CYC > XSNR_CYC) ? MRD_CYC : XSNR_CYC;
   localparam int WIN_W   = $clog2(WIN_MAX + 1);
   localparam int LOCK_W  = $clog2(LOCK_CYC + 1);

   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("ddr_mrs_tracker: ADDR_W must be at least 12");
   end
   if (OP_W < 1 || OP_W > 7) begin : g_bad_op_w
      $error("ddr_mrs_tracker: OP_W must lie in 1..7");
   end
   if (MRD_CYC < 1 || XSNR_CYC < 1 || LOCK_CYC < 1) begin : g_bad_cyc
      $error("ddr_mrs_tracker: wait lengths must be at least 1");
   end

   logic is_mrs, is_rd, is_oth, is_sre, is_srx;
   logic ld_base, ld_ext, base_norm, base_dllrst, rsv;

   ddr_mrs_decode #(.ADDR_W(ADDR_W)) u_dec (
      .cmd_i        (cmd_i),
      .ba_i         (ba_i),
      .addr_i       (addr_i),
      .is_mrs_o     (is_mrs),
      .is_rd_o      (is_rd),
      .is_oth_o     (is_oth),
      .is_sre_o     (is_sre),
      .is_srx_o     (is_srx),
      .ld_base_o    (ld_base),
      .ld_ext_o     (ld_ext),
      .base_norm_o  (base_norm),
      .base_dllrst_o(base_dllrst),
      .rsv_o        (rsv)
   );

   logic [OP_W-1:0] op_q;
   logic            dll_dis_q, drive_q, iso_q;
   logic            dll_on_q, dll_on_d, pend_q;
   logic            win_busy, lock_busy;
   logic            win_load, lock_load;
   logic [WIN_W-1:0] win_val;
   logic [2:0]      code;
   logic            accept;
   logic            viol_q, sticky_q;
   logic [2:0]      code_q;

   ddr_viol_arb u_arb (
      .f_busy_i     (is_mrs && !banks_idle_i),
      .f_early_cmd_i((is_mrs || is_oth) && win_busy),
      .f_early_rd_i (is_rd && (win_busy || lock_busy || !dll_on_q)),
      .f_rsv_i      (rsv),
      .f_no_norm_i  ((is_rd || is_oth) && pend_q),
      .code_o       (code)
   );

   assign accept = is_mrs && (code == V_NONE);

   always_comb begin
      dll_on_d = dll_on_q;
      if (accept && ld_ext)
         dll_on_d = !addr_i[0];
      if (is_sre)
         dll_on_d = 1'b0;
      if (is_srx)
         dll_on_d = !dll_dis_q;
   end

   assign win_load  = accept || is_srx;
   assign win_val   = is_srx ? WIN_W'(XSNR_CYC - 1) : WIN_W'(MRD_CYC - 1);
   assign lock_load = dll_on_d && !dll_on_q;

   ddr_wait_ctr #(.MAX_VAL(WIN_MAX)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(win_load),
      .val_i (win_val),
      .busy_o(win_busy)
   );

   ddr_wait_ctr #(.MAX_VAL(LOCK_CYC)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(lock_load),
      .val_i (LOCK_W'(LOCK_CYC - 1)),
      .busy_o(lock_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q      <= '0;
         pend_q    <= 1'b0;
         dll_dis_q <= 1'b0;
         drive_q   <= 1'b0;
         dll_on_q  <= 1'b0;
         viol_q    <= 1'b0;
         code_q    <= V_NONE;
         sticky_q  <= 1'b0;
      end else begin
         if (accept && ld_base) begin
            op_q   <= addr_i[OP_W-1:0];
            pend_q <= base_dllrst && !base_norm;
         end
         if (accept && ld_ext) begin
            dll_dis_q <= addr_i[0];
            drive_q   <= addr_i[1];
         end
         dll_on_q <= dll_on_d;
         viol_q   <= (code != V_NONE);
         code_q   <= code;
         sticky_q <= sticky_q || (code != V_NONE);
      end
   end

   if (ISO_EN) begin : g_iso
      always_ff @(posedge clk) begin
         if (!rst_n)
            iso_q <= 1'b0;
         else if (accept && ld_ext)
            iso_q <= addr_i[2];
      end
   end else begin : g_no_iso
      assign iso_q = 1'b0;
   end

   assign base_op_o     = op_q;
   assign ext_dll_dis_o = dll_dis_q;
   assign ext_drive_o   = drive_q;
   assign ext_iso_o     = iso_q;
   assign dll_on_o      = dll_on_q;
   assign dll_locked_o  = dll_on_q && !lock_busy;
   assign rst_pending_o = pend_q;
   assign viol_o        = viol_q;
   assign viol_code_o   = code_q;
   assign err_sticky_o  = sticky_q;

endmodule

// File: rtl/ddr_mrs_checker.sv
module ddr_mrs_checker #(
   parameter int OP_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      cmd_i,
   input logic            banks_idle_i,
   input logic [1:0]      ba_i,
   input logic [OP_W-1:0] base_op_o,
   input logic            dll_on_o,
   input logic            dll_locked_o,
   input logic            rst_pending_o,
   input logic            viol_o,
   input logic [2:0]      viol_code_o,
   input logic            err_sticky_o
);
   import ddr_mrs_pkg::*;

   p_code_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o == (viol_code_o != 3'd0));

   p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> err_sticky_o);

   p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky_o |=> err_sticky_o);

   p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_MRS && !banks_idle_i)
      |=> (viol_o && viol_code_o == V_BUSY && $stable(base_op_o)));

   p_bad_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_MRS && banks_idle_i && ba_i[1])
      |=> (viol_o && (viol_code_o == V_RSV || viol_code_o == V_EARLY_CMD)
           && $stable(base_op_o)));

   p_sre_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_SRE) |=> (!dll_on_o && !dll_locked_o));

   p_lock_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dll_on_o) |-> !dll_locked_o);

   p_locked_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dll_locked_o |-> dll_on_o);

   p_pend_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pending_o) |-> ($past(cmd_i) == CMD_MRS));

endmodule

bind ddr_mrs_tracker ddr_mrs_checker #(.OP_W(OP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_i        (cmd_i),
   .banks_idle_i (banks_idle_i),
   .ba_i         (ba_i),
   .base_op_o    (base_op_o),
   .dll_on_o     (dll_on_o),
   .dll_locked_o (dll_locked_o),
   .rst_pending_o(rst_pending_o),
   .viol_o       (viol_o),
   .viol_code_o  (viol_code_o),
   .err_sticky_o (err_sticky_o)
);

// File: tb/tb_ddr_mrs_tracker.sv
`timescale 1ns/1ps
module tb_ddr_mrs_tracker;

   localparam logic [2:0] C_NOP = 3'd0, C_MRS = 3'd1, C_SRE = 3'd2,
                          C_SRX = 3'd3, C_RD = 3'd4, C_OTH = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_i = C_NOP;
   logic        banks_idle_i = 1'b1;
   logic [1:0]  ba_i = 2'b00;
   logic [11:0] addr_i = '0;
   logic [6:0]  base_op_o;
   logic        ext_dll_dis_o, ext_drive_o, ext_iso_o;
   logic        dll_on_o, dll_locked_o, rst_pending_o;
   logic        viol_o, err_sticky_o;
   logic [2:0]  viol_code_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      logic [2:0] code;
      string      tag;
   } exp_t;

   exp_t q[$];
   exp_t e;

   always #4 clk = ~clk;

   ddr_mrs_tracker dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .banks_idle_i(banks_idle_i),
      .ba_i(ba_i), .addr_i(addr_i), .base_op_o(base_op_o),
      .ext_dll_dis_o(ext_dll_dis_o), .ext_drive_o(ext_drive_o),
      .ext_iso_o(ext_iso_o), .dll_on_o(dll_on_o), .dll_locked_o(dll_locked_o),
      .rst_pending_o(rst_pending_o), .viol_o(viol_o),
      .viol_code_o(viol_code_o), .err_sticky_o(err_sticky_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: one expected violation code per command cycle
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         e = q.pop_front();
         check({e.tag, " code"}, int'(viol_code_o), int'(e.code));
         check({e.tag, " pulse"}, int'(viol_o), int'(e.code != 3'd0));
      end
   end

   task automatic issue(input logic [2:0] c, input logic [1:0] b,
                        input logic [11:0] a, input logic idle,
                        input logic [2:0] exp, input string tag);
      exp_t it;
      @(negedge clk);
      cmd_i = c; ba_i = b; addr_i = a; banks_idle_i = idle;
      it.code = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic nop(input int n, input string tag);
      for (int i = 0; i < n; i++) issue(C_NOP, 2'b00, 12'h000, 1'b1, 3'd0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_i = C_NOP;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 base_op", base_op_o, 0);
      check("R1 dll_on", dll_on_o, 0);
      check("R1 locked", dll_locked_o, 0);
      check("R1 pending", rst_pending_o, 0);
      check("R1 viol", viol_o, 0);
      check("R1 sticky", err_sticky_o, 0);
      check("R1 ext", {ext_dll_dis_o, ext_drive_o, ext_iso_o}, 0);

      // R5/R7/R8: enable loop with isolation on
      issue(C_MRS, 2'b01, 12'h004, 1'b1, 3'd0, "R5 ext load");
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd2, "R7 early other");
      check("R5 dll_on", dll_on_o, 1);
      check("R5 iso", ext_iso_o, 1);
      check("R8 not locked", dll_locked_o, 0);
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd0, "R7 other at 2");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd1, "R8 read at 3");
      nop(195, "R10 idle");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd1, "R8 read at 199");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd0, "R8 read at 200");
      nop(1, "R10 idle");
      check("R8 locked", dll_locked_o, 1);

      // R2 normal base load; read inside post-load wait
      issue(C_MRS, 2'b00, 12'h032, 1'b1, 3'd0, "R2 base load");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd1, "R8 read in load wait");
      check("R2 base_op", base_op_o, 7'h32);
      nop(1, "R10 idle");

      // R3 loop reset then missing normal load
      issue(C_MRS, 2'b00, 12'h115, 1'b1, 3'd0, "R3 reset load");
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd2, "R3 early wins over missing");
      nop(1, "R10 idle");
      check("R3 pending", rst_pending_o, 1);
      check("R3 base_op", base_op_o, 7'h15);
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd5, "R3 other while pending");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd5, "R3 read while pending");
      issue(C_MRS, 2'b00, 12'h015, 1'b1, 3'd0, "R2 closing normal load");
      nop(2, "R10 idle");
      check("R2 pending cleared", rst_pending_o, 0);
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd0, "R2 other after close");

      // R4 reserved values
      issue(C_MRS, 2'b00, 12'h0FF, 1'b1, 3'd4, "R4 base reserved");
      nop(2, "R10 idle");
      check("R4 base kept", base_op_o, 7'h15);
      issue(C_MRS, 2'b01, 12'h009, 1'b1, 3'd4, "R4 ext reserved");
      nop(2, "R10 idle");
      check("R4 ext dis kept", ext_dll_dis_o, 0);
      check("R4 dll kept", dll_on_o, 1);
      issue(C_MRS, 2'b10, 12'h000, 1'b1, 3'd4, "R4 bank bit 1");
      nop(2, "R10 idle");
      check("R4 base kept 2", base_op_o, 7'h15);

      // R6 busy loads, including busy plus reserved
      issue(C_MRS, 2'b00, 12'h033, 1'b0, 3'd3, "R6 busy load");
      issue(C_MRS, 2'b00, 12'h080, 1'b0, 3'd3, "R6 busy beats reserved");
      nop(2, "R10 idle");
      check("R6 base kept", base_op_o, 7'h15);

      // R7 early load rejected
      issue(C_MRS, 2'b00, 12'h011, 1'b1, 3'd0, "R7 first load");
      issue(C_MRS, 2'b00, 12'h022, 1'b1, 3'd2, "R7 early load");
      nop(2, "R10 idle");
      check("R7 early load dropped", base_op_o, 7'h11);

      // R9 self refresh
      issue(C_SRE, 2'b00, 12'h000, 1'b1, 3'd0, "R9 entry");
      nop(1, "R10 idle");
      check("R9 dll off", dll_on_o, 0);
      check("R9 not locked", dll_locked_o, 0);
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd1, "R8 read loop off");
      issue(C_SRX, 2'b00, 12'h000, 1'b1, 3'd0, "R9 exit");
      nop(8, "R10 idle");
      check("R9 dll back on", dll_on_o, 1);
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd2, "R9 other at 9");
      issue(C_OTH, 2'b00, 12'h000, 1'b1, 3'd0, "R9 other at 10");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd1, "R9 read at 11");
      nop(188, "R10 idle");
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd0, "R9 read at 200");

      // R5 disable loop; exit keeps it off
      issue(C_MRS, 2'b01, 12'h005, 1'b1, 3'd0, "R5 ext disable");
      nop(2, "R10 idle");
      check("R5 dis bit", ext_dll_dis_o, 1);
      check("R5 dll off", dll_on_o, 0);
      issue(C_RD, 2'b00, 12'h000, 1'b1, 3'd1, "R8 read disabled");
      issue(C_SRX, 2'b00, 12'h000, 1'b1, 3'd0, "R9 exit while disabled");
      nop(10, "R10 idle");
      check("R9 stays off", dll_on_o, 0);

      // R5 re-enable with drive select
      issue(C_MRS, 2'b01, 12'h006, 1'b1, 3'd0, "R5 ext enable");
      nop(2, "R10 idle");
      check("R5 drive", ext_drive_o, 1);
      check("R5 dll on", dll_on_o, 1);
      check("R8 relock pending", dll_locked_o, 0);
      check("R10 sticky held", err_sticky_o, 1);
      check("R10 no pulse", viol_o, 0);

      // R1 reset again
      do_reset();
      check("R1 sticky cleared", err_sticky_o, 0);
      check("R1 base cleared", base_op_o, 0);
      check("R1 dll cleared", dll_on_o, 0);
      check("R1 ext cleared", {ext_dll_dis_o, ext_drive_o, ext_iso_o}, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule